// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Classifier

The classifier receives two one-bit square waves. One comes from the limiter of the low (row) band and one from the limiter of the high (column) band. Each wave passes through a small synchronizer. The block then times every full cycle of the wave, from rising edge to rising edge, by counting reference clock cycles. It compares each measured period with fixed cycle-count windows for the four row tones and the four column tones. A group counts as valid only after several periods in a row fall into the same window.

When the row group and the column group are both valid, the block raises a pair-present flag and outputs the two 2-bit indices. Any bad period, or a silence longer than about 3 ms, clears the group at once. A mask input can remove the 1633 Hz column. All window limits are computed at elaboration from the reference clock frequency, so a build for a different clock only needs a new parameter value.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While `rst_n` is low, and after its release until a pair is recognised, `pair_valid`, `row_idx` and `col_idx` are all zero.
- R2: The row band is timed from one rising edge to the next. Tones of 697, 770, 852 and 941 Hz give `row_idx` 0, 1, 2 and 3.
- R3: The column band is timed the same way. Tones of 1209, 1336, 1477 and 1633 Hz give `col_idx` 0, 1, 2 and 3.
- R4: A tone that is within ±(1.5 % + 2 Hz) of its nominal frequency is recognised with the nominal index.
- R5: A tone that is off by 3.5 % or more from every nominal is rejected. This includes frequencies in the gap between two neighbouring nominals. A period strictly inside the reject limits is taken as the nearest nominal.
- R6: A group turns valid only after `RUN_NEED` (default 4) consecutive measured periods fall into the same window. Only 3 such periods leave `pair_valid` low.
- R7: One period that lies outside every window clears its group. `pair_valid` then falls within a few clock cycles of that rising edge.
- R8: If no rising edge arrives on a band for `TIMEOUT_US` (default 3000 µs) of reference clock, that group is cleared. The next edge after the timeout only re-arms the timer and does not produce a period.
- R9: While `mask_col3` is high, a 1633 Hz column never raises `pair_valid`. Columns 0 to 2 are not affected.
- R10: `pair_valid` is high only while both groups are valid. While it is low, `row_idx` and `col_idx` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_lo | input | 1 | Limited square wave of the row band (asynchronous) |
| tone_hi | input | 1 | Limited square wave of the column band (asynchronous) |
| mask_col3 | input | 1 | High: a 1633 Hz column is not treated as valid |
| pair_valid | output | 1 | Both groups currently hold a valid tone |
| row_idx | output | 2 | Row index, meaningful while pair_valid is high |
| col_idx | output | 2 | Column index, meaningful while pair_valid is high |

## Verification
The bench drives all four rows and all four columns at their nominal periods, and checks that every index maps to exactly one frequency. Periods just inside the accept band are told apart from periods just past the reject limit and from periods in the gap between two rows. A tone present on only one band, and a column outside every window, show that both groups are needed. The masked 1633 Hz column is tried beside a masked run on another column, and directed start-up, single-bad-period, silence and mid-run reset cases separate the smoothing rule from the timeout and the immediate drop.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    typedef logic [1:0] bin_t;

    // nominal tone of a band: grp 0 = row band, grp 1 = column band
    function automatic longint nominal_hz(input int grp, input int idx);
        longint f;
        if (grp == 0) begin
            case (idx)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (idx)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // smallest period (cycles) whose frequency is below f*(1+rej)
    function automatic longint period_min(input longint clk_hz, input longint f,
                                          input int rej_permil);
        return (clk_hz * 1000) / (f * (1000 + rej_permil)) + 1;
    endfunction

    // largest period (cycles) whose frequency is above f*(1-rej)
    function automatic longint period_max(input longint clk_hz, input longint f,
                                          input int rej_permil);
        return (clk_hz * 1000 - 1) / (f * (1000 - rej_permil));
    endfunction

    function automatic int timeout_cycles(input longint clk_hz, input longint us);
        return int'((clk_hz * us) / 1000000);
    endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
    parameter int SYNC_STAGES = 2,
    parameter int TO_CYC      = 10738,
    parameter int PW          = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tone_in,
    output logic          period_stb,
    output logic [PW-1:0] period,
    output logic          timeout_stb
);

    localparam logic [PW-1:0] TO_P = PW'(TO_CYC);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [PW-1:0]          cnt;
        logic                   armed;
        logic                   stb;
        logic [PW-1:0]          per;
        logic                   tmo;
    } meter_t;

    meter_t st_q, st_d;
    logic   rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], tone_in};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        st_d.stb  = 1'b0;
        st_d.tmo  = 1'b0;
        rise      = st_q.sync[SYNC_STAGES-1] && !st_q.prev;
        if (rise) begin
            if (st_q.armed) begin
                st_d.stb = 1'b1;
                st_d.per = st_q.cnt;
            end
            st_d.cnt   = PW'(1);
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            if (st_q.cnt >= TO_P) begin
                st_d.armed = 1'b0;
                st_d.tmo   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_stb  = st_q.stb;
    assign period      = st_q.per;
    assign timeout_stb = st_q.tmo;

    AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |-> (period != '0 && period <= TO_P)); // R2

    AST_NO_PERIOD_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_stb |=> !period_stb); // R8

endmodule

// File: rtl/dtmf_bin_match.sv
module dtmf_bin_match
    import dtmf_cls_pkg::*;
#(
    parameter int     GROUP      = 0,
    parameter longint CLK_HZ     = 3579545,
    parameter int     REJ_PERMIL = 35,
    parameter int     PW         = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    output logic          in_bin,
    output bin_t          bin
);

    localparam int NBINS = 4;

    logic [NBINS-1:0] hit;

    for (genvar i = 0; i < NBINS; i++) begin : g_win
        localparam longint F_HZ = nominal_hz(GROUP, i);
        localparam logic [PW-1:0] P_LO = PW'(period_min(CLK_HZ, F_HZ, REJ_PERMIL));
        localparam logic [PW-1:0] P_HI = PW'(period_max(CLK_HZ, F_HZ, REJ_PERMIL));
        assign hit[i] = (period >= P_LO) && (period <= P_HI);
    end

    always_comb begin
        bin = '0;
        for (int i = 0; i < NBINS; i++) begin
            if (hit[i]) bin = bin_t'(i);
        end
    end

    assign in_bin = |hit;

    AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R5

endmodule

// File: rtl/dtmf_group_track.sv
module dtmf_group_track
    import dtmf_cls_pkg::*;
#(
    parameter int RUN_NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_stb,
    input  logic in_bin,
    input  bin_t bin,
    input  logic timeout_stb,
    output logic valid,
    output bin_t idx
);

    localparam int RW = $clog2(RUN_NEED + 1);
    localparam logic [RW-1:0] NEED_R = RW'(RUN_NEED);

    typedef struct packed {
        bin_t          last;
        logic [RW-1:0] run;
        logic          valid;
    } track_t;

    track_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (timeout_stb) begin
            st_d.run = '0;
        end else if (period_stb) begin
            if (in_bin && st_q.run != '0 && bin == st_q.last) begin
                st_d.run = (st_q.run == NEED_R) ? NEED_R : st_q.run + RW'(1);
            end else if (in_bin) begin
                st_d.run  = RW'(1);
                st_d.last = bin;
            end else begin
                st_d.run = '0;
            end
        end
        st_d.valid = (st_d.run == NEED_R);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign idx   = st_q.last;

    AST_RISE_ON_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(period_stb)); // R6

    AST_BAD_PERIOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (period_stb && !in_bin) |=> !valid); // R7

    AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_stb |=> !valid); // R8

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter longint CLK_HZ      = 3579545,
    parameter int     TIMEOUT_US  = 3000,
    parameter int     REJ_PERMIL  = 35,
    parameter int     RUN_NEED    = 4,
    parameter int     SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_lo,
    input  logic       tone_hi,
    input  logic       mask_col3,
    output logic       pair_valid,
    output logic [1:0] row_idx,
    output logic [1:0] col_idx
);

    localparam int NGRP   = 2;
    localparam int TO_CYC = timeout_cycles(CLK_HZ, longint'(TIMEOUT_US));
    localparam int PW     = $clog2(TO_CYC + 1);

    logic [NGRP-1:0] tone_vec;
    logic [NGRP-1:0] grp_valid;
    bin_t            grp_idx [NGRP];

    assign tone_vec = {tone_hi, tone_lo};

    for (genvar g = 0; g < NGRP; g++) begin : g_band
        logic          p_stb;
        logic [PW-1:0] p_val;
        logic          t_stb;
        logic          m_hit;
        bin_t          m_bin;

        dtmf_period_meter #(
            .SYNC_STAGES (SYNC_STAGES),
            .TO_CYC      (TO_CYC),
            .PW          (PW)
        ) u_meter (
            .clk         (clk),
            .rst_n       (rst_n),
            .tone_in     (tone_vec[g]),
            .period_stb  (p_stb),
            .period      (p_val),
            .timeout_stb (t_stb)
        );

        dtmf_bin_match #(
            .GROUP      (g),
            .CLK_HZ     (CLK_HZ),
            .REJ_PERMIL (REJ_PERMIL),
            .PW         (PW)
        ) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .period (p_val),
            .in_bin (m_hit),
            .bin    (m_bin)
        );

        dtmf_group_track #(
            .RUN_NEED (RUN_NEED)
        ) u_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .period_stb  (p_stb),
            .in_bin      (m_hit),
            .bin         (m_bin),
            .timeout_stb (t_stb),
            .valid       (grp_valid[g]),
            .idx         (grp_idx[g])
        );
    end

    typedef struct packed {
        logic est;
        bin_t row;
        bin_t col;
    } out_t;

    out_t st_q, st_d;
    logic col_ok;

    always_comb begin
        col_ok  = grp_valid[1] && !(mask_col3 && grp_idx[1] == 2'd3);
        st_d.est = grp_valid[0] && col_ok;
        st_d.row = st_d.est ? grp_idx[0] : '0;
        st_d.col = st_d.est ? grp_idx[1] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid = st_q.est;
    assign row_idx    = st_q.row;
    assign col_idx    = st_q.col;

    AST_IDLE_INDICES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> (row_idx == 2'd0 && col_idx == 2'd0)); // R10

    AST_MASKED_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && col_idx == 2'd3) |-> !$past(mask_col3)); // R9

endmodule

// File: tb/sim_dtmf_pair_classifier.sv
module sim_dtmf_pair_classifier;

    localparam int     CLK_PERIOD = 10;
    localparam longint TB_CLK_HZ  = 357954;   // reference scaled by 1/10
    localparam int     SETTLE     = 5000;
    localparam int     NVEC       = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_lo = 1'b0;
    logic       tone_hi = 1'b0;
    logic       mask_col3 = 1'b0;
    logic       pair_valid;
    logic [1:0] row_idx;
    logic [1:0] col_idx;

    int lo_per = 0;
    int hi_per = 0;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtmf_pair_classifier #(
        .CLK_HZ (TB_CLK_HZ)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_lo    (tone_lo),
        .tone_hi    (tone_hi),
        .mask_col3  (mask_col3),
        .pair_valid (pair_valid),
        .row_idx    (row_idx),
        .col_idx    (col_idx)
    );

    // square-wave sources, period given in clock cycles, 0 = silent
    initial forever begin
        if (lo_per == 0) begin
            tone_lo = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = lo_per;
            tone_lo = 1'b1;
            repeat (p/2) @(negedge clk);
            tone_lo = 1'b0;
            repeat (p - p/2) @(negedge clk);
        end
    end

    initial forever begin
        if (hi_per == 0) begin
            tone_hi = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = hi_per;
            tone_hi = 1'b1;
            repeat (p/2) @(negedge clk);
            tone_hi = 1'b0;
            repeat (p - p/2) @(negedge clk);
        end
    end

    task automatic chk(input string req, input logic e_est,
                       input logic [1:0] e_row, input logic [1:0] e_col);
        checks++;
        if ({pair_valid, row_idx, col_idx} !== {e_est, e_row, e_col}) begin
            errors++;
            $display("FAIL %s: got valid=%0b row=%0d col=%0d, expected valid=%0b row=%0d col=%0d",
                     req, pair_valid, row_idx, col_idx, e_est, e_row, e_col);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // lo period, hi period, mask, expected valid, row, col
    // at 357954 Hz: 697->514 770->465 852->420 941->380
    //               1209->296 1336->268 1477->242 1633->219
    localparam int VEC [NVEC][6] = '{
        '{514, 296, 0, 1, 0, 0},   // R2 R3 key row0/col0
        '{465, 268, 0, 1, 1, 1},   // R2 R3
        '{420, 242, 0, 1, 2, 2},   // R2 R3
        '{380, 219, 0, 1, 3, 3},   // R2 R3
        '{514, 219, 1, 0, 0, 0},   // R9 masked 1633
        '{380, 268, 1, 1, 3, 1},   // R9 mask leaves col1 alone
        '{505, 296, 0, 1, 0, 0},   // R4 697 +1.7 %
        '{387, 242, 0, 1, 3, 2},   // R4 941 -1.7 %
        '{495, 296, 0, 0, 0, 0},   // R5 697 +3.75 %
        '{490, 268, 0, 0, 0, 0},   // R5 gap between 697 and 770
        '{514,   0, 0, 0, 0, 0},   // R10 column silent
        '{  0, 296, 0, 0, 0, 0},   // R10 row silent
        '{465, 330, 0, 0, 0, 0},   // R5 column 1085 Hz outside all
        '{420, 219, 0, 1, 2, 3}    // R3 1633 without mask
    };

    initial begin
        // R1: reset state
        mask_col3 = 1'b0;
        rst_n = 1'b0;
        wait_cyc(5);
        chk("R1 in reset", 1'b0, 2'd0, 2'd0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1 after reset", 1'b0, 2'd0, 2'd0);

        // R6: smoothing over four periods from silence
        lo_per = 514;
        hi_per = 296;
        wait_cyc(3*514 + 257);
        chk("R6 three periods only", 1'b0, 2'd0, 2'd0);
        wait_cyc(514 - 257 + 30);
        chk("R6 four periods", 1'b1, 2'd0, 2'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            lo_per    = VEC[v][0];
            hi_per    = VEC[v][1];
            mask_col3 = VEC[v][2][0];
            wait_cyc(SETTLE);
            chk($sformatf("R2/R3/R4/R5/R9/R10 vector %0d", v), VEC[v][3][0],
                VEC[v][4][1:0], VEC[v][5][1:0]);
        end
        mask_col3 = 1'b0;

        // R7: one bad column period drops the pair quickly
        lo_per = 465;
        hi_per = 268;
        wait_cyc(SETTLE);
        chk("R7 before bad period", 1'b1, 2'd1, 2'd1);
        hi_per = 150;
        wait_cyc(268 + 150 + 30);
        chk("R7 after bad period", 1'b0, 2'd0, 2'd0);

        // R8: silence on the column band clears only after the timeout
        hi_per = 268;
        wait_cyc(SETTLE);
        chk("R8 recovered", 1'b1, 2'd1, 2'd1);
        hi_per = 0;
        wait_cyc(700);
        chk("R8 before timeout", 1'b1, 2'd1, 2'd1);
        wait_cyc(1073 + 40 - 700);
        chk("R8 after timeout", 1'b0, 2'd0, 2'd0);

        // R1: reset in the middle of a valid pair
        hi_per = 268;
        wait_cyc(SETTLE);
        rst_n = 1'b0;
        wait_cyc(3);
        chk("R1 mid-run reset", 1'b0, 2'd0, 2'd0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 just after reset", 1'b0, 2'd0, 2'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule